// File: doc/BRIEF.md
# Serial Sector CRC Generator and Checker

This block runs a 16-bit cyclic redundancy check over the serial bit stream of one disc sector. Software or a sequencer opens each sector with a start pulse that also selects the direction. While writing, every data bit headed for the write encoder is also strobed into the block; once the data field is closed, the block serialises its 16-bit remainder so that the two check bytes follow the data on the medium with no gap.

While reading, the separated data bits and then the two recorded check bytes are strobed through the same engine. Because the register is preset to all ones and no final inversion is applied, an undamaged field leaves a zero residue; any other residue raises an error flag that the controller reads as a status bit once the field has ended. The flag and a done indication stay put until the next sector starts.

Top module: `sector_crc`

## Requirements
- R1: After reset, `crc_bit_vld_o`, `crc_err_o` and `sec_done_o` are low and strobed bits have no effect until a start pulse.
- R2: A cycle with `sec_start_i` high presets the register to 16'hFFFF, clears `crc_err_o` and `sec_done_o`, latches `wr_mode_i` (1 = write, 0 = read) and opens the data field; it overrides any other input in that cycle, and a bit strobed in that cycle is discarded.
- R3: In the data field each cycle with `bit_vld_i` high folds `bit_i` into the register using the generator x^16 + x^12 + x^5 + 1 (feedback constant 16'h1021), earliest bit treated as the most significant.
- R4: A cycle with `data_end_i` high in the data field closes it; a bit strobed in that same cycle is the last data bit.
- R5: In write mode, after the data field `crc_bit_vld_o` is high and `crc_bit_o` shows the current remainder bit; each strobe advances by one, giving 16 bits with the high byte first and each byte most significant bit first. The value of `bit_i` has no effect on these bits.
- R6: In read mode, after the data field the next 16 strobed bits are folded in as well; after the 16th, `sec_done_o` rises and `crc_err_o` is high exactly when the residue is non-zero.
- R7: In write mode `crc_err_o` never goes high.
- R8: Once `sec_done_o` is high it and `crc_err_o` hold, and strobes and `data_end_i` are ignored, until the next start.
- R9: Cycles with `bit_vld_i` low advance neither the register nor the check-bit count, so strobes may arrive with arbitrary gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_start_i | input | 1 | Opens a new sector |
| wr_mode_i | input | 1 | Direction, sampled at start: 1 write, 0 read |
| bit_vld_i | input | 1 | Bit strobe |
| bit_i | input | 1 | Serial data or recorded check bit |
| data_end_i | input | 1 | Closes the data field |
| crc_bit_o | output | 1 | Serial check bit during write emission |
| crc_bit_vld_o | output | 1 | High while check bits are being emitted |
| crc_err_o | output | 1 | Read residue was non-zero |
| sec_done_o | output | 1 | Sector finished |

## Verification
A corrupted remainder stays hidden during the data field and only surfaces at the end: on write as a wrong bit on `crc_bit_o` in the very strobe where the damaged position is emitted, on read as a wrong `crc_err_o` in the cycle after the 16th check bit. A miscounted check-bit counter shows as `sec_done_o` rising one strobe early or late, and a wrong phase shows as `crc_bit_vld_o` on the wrong cycles. The bench keeps its own sector model and compares all four outputs on every clock, so each of these appears in the first cycle it becomes visible, besides a known-answer sector and read-back of written sectors with and without a flipped bit.

// File: rtl/sector_crc_pkg.sv
`timescale 1ns/1ps
package sector_crc_pkg;
  localparam int unsigned CRC_W_DEF = 16;
  localparam logic [15:0] CRC_POLY_DEF = 16'h1021;
  localparam logic [15:0] CRC_INIT_DEF = 16'hFFFF;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DATA  = 3'd1,
    PH_CHECK = 3'd2,
    PH_EMIT  = 3'd3,
    PH_DONE  = 3'd4
  } sec_phase_e;
endpackage

// File: rtl/sector_crc_engine.sv
`timescale 1ns/1ps
module sector_crc_engine #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preset_i,
  input  logic         step_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o,
  output logic         step_zero_o
);

  // One bit of polynomial division, most significant bit first.
  function automatic logic [W-1:0] crc_next(input logic [W-1:0] r, input logic b);
    logic fb;
    fb = r[W-1] ^ b;
    return {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  logic [W-1:0] crc_q;
  logic [W-1:0] stepped;

  assign stepped = crc_next(crc_q, bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= INIT;
    else if (preset_i) crc_q <= INIT;
    else if (step_i)   crc_q <= stepped;
    else if (shift_i)  crc_q <= {crc_q[W-2:0], 1'b0};
  end

  assign crc_o       = crc_q;
  assign step_zero_o = (stepped == '0);

  p_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> crc_q == INIT);
  p_gap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && !step_i && !shift_i) |=> $stable(crc_q));
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_i, shift_i}));

endmodule

// File: rtl/sector_crc_seq.sv
`timescale 1ns/1ps
module sector_crc_seq
  import sector_crc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_mode_i,
  input  logic bit_vld_i,
  input  logic data_end_i,
  input  logic step_zero_i,
  output logic preset_o,
  output logic step_o,
  output logic shift_o,
  output logic emit_o,
  output logic done_o,
  output logic err_o
);

  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  sec_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             err_q;

  // Named events for the assertions.
  logic in_data, in_tail, ev_tail, ev_last;
  assign in_data = (phase_q == PH_DATA);
  assign in_tail = (phase_q == PH_CHECK) || (phase_q == PH_EMIT);
  assign ev_tail = !start_i && bit_vld_i && in_tail;
  assign ev_last = ev_tail && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      wr_q    <= wr_mode_i;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_DATA: if (data_end_i) begin
          phase_q <= wr_q ? PH_EMIT : PH_CHECK;
          cnt_q   <= '0;
        end
        PH_CHECK, PH_EMIT: if (ev_tail) begin
          cnt_q <= cnt_q + 1'b1;
          if (ev_last) begin
            phase_q <= PH_DONE;
            if (phase_q == PH_CHECK) err_q <= !step_zero_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign preset_o = start_i;
  assign step_o   = !start_i && bit_vld_i && (in_data || (phase_q == PH_CHECK));
  assign shift_o  = !start_i && bit_vld_i && (phase_q == PH_EMIT);
  assign emit_o   = (phase_q == PH_EMIT);
  assign done_o   = (phase_q == PH_DONE);
  assign err_o    = err_q;

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !err_o && !done_o && !emit_o);
  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(err_o));
  p_no_err_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> !err_o);
  p_tail_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ev_last));
  p_gap_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tail && !bit_vld_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sector_crc.sv
`timescale 1ns/1ps
module sector_crc
  import sector_crc_pkg::*;
#(
  parameter int unsigned  W    = CRC_W_DEF,
  parameter logic [W-1:0] POLY = CRC_POLY_DEF,
  parameter logic [W-1:0] INIT = CRC_INIT_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_start_i,
  input  logic wr_mode_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic data_end_i,
  output logic crc_bit_o,
  output logic crc_bit_vld_o,
  output logic crc_err_o,
  output logic sec_done_o
);

  logic         preset, step, shift, step_zero, emit;
  logic [W-1:0] crc;

  sector_crc_seq #(.W(W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (sec_start_i),
    .wr_mode_i  (wr_mode_i),
    .bit_vld_i  (bit_vld_i),
    .data_end_i (data_end_i),
    .step_zero_i(step_zero),
    .preset_o   (preset),
    .step_o     (step),
    .shift_o    (shift),
    .emit_o     (emit),
    .done_o     (sec_done_o),
    .err_o      (crc_err_o)
  );

  sector_crc_engine #(.W(W), .POLY(POLY), .INIT(INIT)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .preset_i   (preset),
    .step_i     (step),
    .shift_i    (shift),
    .bit_i      (bit_i),
    .crc_o      (crc),
    .step_zero_o(step_zero)
  );

  assign crc_bit_vld_o = emit;
  assign crc_bit_o     = emit & crc[W-1];

  p_vld_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crc_bit_vld_o, sec_done_o}));

endmodule

// File: tb/test_sector_crc.sv
`timescale 1ns/1ps
module test_sector_crc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, wr = 0, vld = 0, din = 0, dend = 0;
  logic crc_bit, crc_bit_vld, crc_err, done;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sector_crc i_sector_crc (
    .clk_i(clk), .rst_ni(rst_n), .sec_start_i(start), .wr_mode_i(wr),
    .bit_vld_i(vld), .bit_i(din), .data_end_i(dend),
    .crc_bit_o(crc_bit), .crc_bit_vld_o(crc_bit_vld),
    .crc_err_o(crc_err), .sec_done_o(done)
  );

  // Behavioural reference: 0 idle, 1 data, 2 read tail, 3 write tail, 4 done
  int m_ph = 0, m_k = 0, m_wr = 0, m_err = 0;
  int unsigned m_crc = 0, m_snap = 0;

  function automatic int unsigned fold(int unsigned c, int b);
    int fb = ((c >> 15) & 1) ^ b;
    c = (c << 1) & 32'hFFFF;
    if (fb != 0) c = c ^ 32'h1021;
    return c;
  endfunction

  function automatic int unsigned crc_bytes(byte unsigned q[$]);
    int unsigned c = 32'hFFFF;
    foreach (q[i]) for (int j = 7; j >= 0; j--) c = fold(c, (q[i] >> j) & 1);
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_err = 0; m_k = 0;
    end else if (start) begin
      m_ph = 1; m_crc = 32'hFFFF; m_err = 0; m_wr = wr;
    end else begin
      case (m_ph)
        1: begin
          if (vld) m_crc = fold(m_crc, din);
          if (dend) begin m_ph = m_wr ? 3 : 2; m_k = 0; m_snap = m_crc; end
        end
        2: if (vld) begin
          m_crc = fold(m_crc, din); m_k++;
          if (m_k == 16) begin m_ph = 4; m_err = (m_crc != 0); end
        end
        3: if (vld) begin m_k++; if (m_k == 16) m_ph = 4; end
        default: ;
      endcase
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    int ebit;
    ebit = (m_ph == 3) ? ((m_snap >> (15 - m_k)) & 1) : 0;
    check(crc_bit_vld == (m_ph == 3), "R5 vld", crc_bit_vld, m_ph == 3);
    check(crc_bit == ebit, "R5 bit", crc_bit, ebit);
    check(crc_err == m_err, "R6 err", crc_err, m_err);
    check(done == (m_ph == 4), "R8 done", done, m_ph == 4);
  end

  task automatic drive(bit s, bit w, bit v, bit b, bit e);
    @(posedge clk); #1;
    start = s; wr = w; vld = v; din = b; dend = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, $urandom_range(0, 1), 0);
  endtask

  // Strobe a byte stream, closing the field with the final bit (or alone when empty)
  task automatic send_field(byte unsigned q[$], bit gaps, int flip);
    int idx = 0;
    int total = q.size() * 8;
    foreach (q[i]) for (int j = 7; j >= 0; j--) begin
      bit b = (q[i] >> j) & 1;
      if (idx == flip) b = ~b;
      if (gaps && $urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
      idx++;
      drive(0, 0, 1, b, idx == total);
    end
    if (total == 0) drive(0, 0, 0, 0, 1);
  endtask

  task automatic write_sector(byte unsigned q[$], bit gaps, output int unsigned got);
    drive(1, 1, 0, 0, 0);
    send_field(q, gaps, -1);
    got = 0;
    for (int i = 0; i < 16; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) idle(1);
      drive(0, 0, 1, $urandom_range(0, 1), 0);
      @(negedge clk);
      got = (got << 1) | crc_bit;
    end
    idle(1);
  endtask

  task automatic read_sector(byte unsigned q[$], int unsigned c, bit gaps, int flip);
    byte unsigned full[$];
    full = q;
    drive(1, 0, 0, 0, 0);
    send_field(full, gaps, flip);
    for (int j = 15; j >= 0; j--) begin
      if (gaps && $urandom_range(0, 2) == 0) idle(1);
      drive(0, 0, 1, (c >> j) & 1, 0);
    end
    idle(1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    byte unsigned q[$];
    int unsigned got, c;
    idle(3);
    @(negedge clk);
    check(!crc_bit_vld && !crc_err && !done, "R1 reset", {crc_bit_vld, crc_err, done}, 0);
    rst_n = 1;
    // R1: strobes before any start do nothing
    for (int i = 0; i < 8; i++) drive(0, 0, 1, 1, i == 7);
    @(negedge clk);
    check(!crc_bit_vld && !done, "R1 idle", {crc_bit_vld, done}, 0);

    // R3 R5: known answer, ASCII 1..9 gives 16'h29B1
    q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    write_sector(q, 0, got);
    check(got == 32'h29B1, "R5 known", got, 32'h29B1);
    check(done && !crc_err, "R7 write no err", {done, crc_err}, 2);

    // R6: clean read-back
    read_sector(q, 32'h29B1, 0, -1);
    check(done && !crc_err, "R6 clean", crc_err, 0);
    // R8: strobes after done ignored
    for (int i = 0; i < 10; i++) drive(0, 0, 1, 1, i == 5);
    @(negedge clk);
    check(done && !crc_err, "R8 hold", {done, crc_err}, 2);

    // R6: flipped data bit
    read_sector(q, 32'h29B1, 0, 13);
    check(crc_err == 1, "R6 corrupt", crc_err, 1);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 0, 0);
    @(negedge clk);
    check(crc_err && done, "R8 err hold", {crc_err, done}, 3);

    // R4: empty field emits the preset value
    q = {};
    write_sector(q, 0, got);
    check(got == 32'hFFFF, "R4 empty", got, 32'hFFFF);

    // R2: restart mid-sector with a bit strobed during start
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_field(q, 0, -1);
    got = 0;
    for (int i = 0; i < 16; i++) begin
      drive(0, 0, 1, 0, 0); @(negedge clk); got = (got << 1) | crc_bit;
    end
    check(got == 32'h29B1, "R2 restart", got, 32'h29B1);
    idle(1);

    // R9 and random sectors with gaps
    for (int t = 0; t < 60; t++) begin
      q = {};
      for (int i = 0; i < $urandom_range(0, 6); i++) q.push_back(8'($urandom));
      c = crc_bytes(q);
      if ($urandom_range(0, 1) == 1) begin
        write_sector(q, 1, got);
        check(got == c, "R9 gaps write", got, c);
      end else begin
        int fl = (q.size() > 0 && $urandom_range(0, 1) == 1)
                 ? $urandom_range(0, q.size() * 8 - 1) : -1;
        read_sector(q, c, 1, fl);
        check(crc_err == (fl >= 0), "R6 random read", crc_err, fl >= 0);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule